// File: doc/BRIEF.md
# Pre-Access Buffered Low-Power Cache Read Controller

This block is the read path of a small set-associative cache. Each request can use one of two access modes, and the controller picks one per request to save array energy. Every way keeps its tag and its line data in separate arrays, and each array has its own read enable. A one-entry hint register holds the tag and the way of the most recent hit or fill.

When a request arrives, its tag is compared with the hint before any tag array is enabled.

- **Tag matches the hint.** Only the hinted way's tag array and data array are read, which is way-predicted access.
- **Tag does not match.** Every tag array is read in the first cycle. Only the data array of the way that hits is read in the next cycle, which is phased access.

If a predicted access misses in the hinted way, the other ways' tags are read in a second cycle. A request that misses in every way is served by fetching the line from the next memory level. That line goes into a round-robin victim way.

Two running counters add up the tag-array reads and the data-array reads. They serve as an energy figure. A CPU-side core drives requests through a valid/ready port with one request in flight. A refill port on the other side fetches whole lines.

Top module: `pab_cache`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `refill_req_valid` are 0, both counters are 0, and the hint is empty, so the first request is served with phased access.
- R2: When the request tag equals the hint tag and the line is present in the hinted way, the word is returned 1 cycle after acceptance. Exactly one tag array and one data array are read.
- R3: When the request tag differs from the hint tag and the line is present, all WAYS tag arrays are read, then one data array. The word is returned 2 cycles after acceptance.
- R4: When the request tag equals the hint tag but the line sits in another way, the remaining WAYS-1 tag arrays are read in the second cycle and the data array in the third. The word is returned 3 cycles after acceptance, for a total of WAYS tag reads and 2 data reads.
- R5: A miss in all ways raises `refill_req_valid` with the line-aligned address, where bits below log2(LINE_BYTES) are 0. The request stays high and the address stays stable until `refill_rsp_valid`. The requested word is then returned from the refill line.
- R6: The victim for a fill is chosen by a per-set round-robin pointer. The pointer starts at way 0 after reset and advances by one, wrapping, on every fill of that set.
- R7: Every hit and every fill overwrites the hint with the request tag and the way that supplied the line.
- R8: `rsp_valid` is a one-cycle pulse. `rsp_data` is word k of the line, where k = address bits [log2(LINE_BYTES)-1:2], and word k sits in line bits [32k+31:32k].
- R9: `req_ready` is 1 only when no request is in flight, and it drops in the cycle after a request is accepted.
- R10: Each cycle, the tag counter rises by the number of tag arrays enabled and the data counter by the number of data arrays enabled. Filling a line adds no reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Controller idle, request accepted |
| req_addr | input | AW | Byte address of the word to read |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | DW | Read data word |
| refill_req_valid | output | 1 | Line fetch request to next level |
| refill_req_addr | output | AW | Line-aligned fetch address |
| refill_rsp_valid | input | 1 | Fetched line valid pulse |
| refill_rsp_data | input | LINE_BYTES*8 | Fetched line, word 0 in the low bits |
| tag_rd_count | output | CW | Running total of tag-array reads |
| data_rd_count | output | CW | Running total of data-array reads |

## Verification
The bench builds the block with 2 ways, 4 sets, 8-byte lines and 16-bit addresses. With this configuration three or more tags per set force evictions after a few requests, and round-robin victims alternate between two ways. The bench sweeps every set and word position over several tags, with repeated and cross-set patterns. This reaches all four outcomes: predicted hit, predicted miss that hits elsewhere, phased hit, and full miss. The bench then checks latency, data and counter increments against its own model of the tags and the hint.

// File: rtl/pab_pkg.sv
package pab_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRED,
    ST_PHASE,
    ST_REST,
    ST_DATA,
    ST_FILL
  } pab_state_e;
endpackage

// File: rtl/pab_way_bank.sv
module pab_way_bank #(
  parameter int IDX_W     = 4,
  parameter int TAG_W     = 24,
  parameter int LINE_BITS = 128
) (
  input  logic                 clk,
  input  logic [IDX_W-1:0]     rd_idx,
  input  logic                 tag_en,
  input  logic                 data_en,
  output logic [TAG_W-1:0]     tag_q,
  output logic [LINE_BITS-1:0] data_q,
  input  logic                 we,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [TAG_W-1:0]     wr_tag,
  input  logic [LINE_BITS-1:0] wr_line
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0]     tag_mem  [DEPTH];
  logic [LINE_BITS-1:0] line_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) tag_mem[wr_idx] <= wr_tag;
    if (tag_en) tag_q <= tag_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (we) line_mem[wr_idx] <= wr_line;
    if (data_en) data_q <= line_mem[rd_idx];
  end
endmodule

// File: rtl/pab_hint_buf.sv
module pab_hint_buf #(
  parameter int TAG_W = 24,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic [WAY_W-1:0] upd_way,
  input  logic [TAG_W-1:0] look_tag,
  output logic             match,
  output logic [WAY_W-1:0] hint_way
);
  logic             valid_r;
  logic [TAG_W-1:0] tag_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_r  <= 1'b0;
      tag_r    <= '0;
      hint_way <= '0;
    end else if (upd_en) begin
      valid_r  <= 1'b1;
      tag_r    <= upd_tag;
      hint_way <= upd_way;
    end
  end

  assign match = valid_r && (tag_r == look_tag);
endmodule

// File: rtl/pab_rr_victim.sv
module pab_rr_victim #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int WAY_W = 2,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [IDX_W-1:0] set_idx,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] ptr [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) ptr[s] <= '0;
    end else if (adv) begin
      ptr[set_idx] <= (ptr[set_idx] == WAY_W'(WAYS - 1)) ? '0 : ptr[set_idx] + 1'b1;
    end
  end

  assign victim = ptr[set_idx];
endmodule

// File: rtl/pab_cache.sv
module pab_cache #(
  parameter int WAYS       = 4,
  parameter int SETS       = 16,
  parameter int LINE_BYTES = 16,
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int CW         = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [AW-1:0]           req_addr,
  output logic                    rsp_valid,
  output logic [DW-1:0]           rsp_data,
  output logic                    refill_req_valid,
  output logic [AW-1:0]           refill_req_addr,
  input  logic                    refill_rsp_valid,
  input  logic [LINE_BYTES*8-1:0] refill_rsp_data,
  output logic [CW-1:0]           tag_rd_count,
  output logic [CW-1:0]           data_rd_count
);
  import pab_pkg::*;

  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int IDX_W     = $clog2(SETS);
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int BOFF_W    = $clog2(DW / 8);
  localparam int WORDS     = LINE_BYTES / (DW / 8);
  localparam int WSEL_W    = $clog2(WORDS);
  localparam int TAG_W     = AW - IDX_W - OFF_W;
  localparam int LINE_BITS = LINE_BYTES * 8;

  function automatic logic [WAYS-1:0] way_bit(input logic [WAY_W-1:0] w);
    way_bit = '0;
    way_bit[w] = 1'b1;
  endfunction

  pab_state_e state;

  logic [TAG_W-1:0]  q_tag;
  logic [IDX_W-1:0]  q_idx;
  logic [WSEL_W-1:0] q_wsel;
  logic [WAY_W-1:0]  pred_way_r, hit_way_r, hit_idx, upd_way, victim, hint_way;
  logic [WAYS-1:0]   rd_mask, tag_en, data_en, hit_vec, fill_we;
  logic [WAYS-1:0]   vld [SETS];
  logic [IDX_W-1:0]  rd_idx;
  logic              hint_match, hint_upd, fill_now, any_hit;

  logic [TAG_W-1:0]     tag_q  [WAYS];
  logic [LINE_BITS-1:0] data_q [WAYS];

  wire [TAG_W-1:0]  req_tag  = req_addr[AW-1 -: TAG_W];
  wire [IDX_W-1:0]  req_idx  = req_addr[OFF_W +: IDX_W];
  wire [WSEL_W-1:0] req_wsel = req_addr[BOFF_W +: WSEL_W];

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign fill_we[w] = fill_now && (victim == WAY_W'(w));
      assign hit_vec[w] = rd_mask[w] && vld[q_idx][w] && (tag_q[w] == q_tag);
      pab_way_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_BITS(LINE_BITS)) u_bank (
        .clk(clk), .rd_idx(rd_idx), .tag_en(tag_en[w]), .data_en(data_en[w]),
        .tag_q(tag_q[w]), .data_q(data_q[w]), .we(fill_we[w]), .wr_idx(q_idx),
        .wr_tag(q_tag), .wr_line(refill_rsp_data)
      );
    end
  endgenerate

  pab_hint_buf #(.TAG_W(TAG_W), .WAY_W(WAY_W)) u_hint (
    .clk(clk), .rst(rst), .upd_en(hint_upd), .upd_tag(q_tag), .upd_way(upd_way),
    .look_tag(req_tag), .match(hint_match), .hint_way(hint_way)
  );

  pab_rr_victim #(.WAYS(WAYS), .SETS(SETS), .WAY_W(WAY_W), .IDX_W(IDX_W)) u_rr (
    .clk(clk), .rst(rst), .adv(fill_now), .set_idx(q_idx), .victim(victim)
  );

  assign any_hit   = |hit_vec;
  assign req_ready = (state == ST_IDLE);

  always_comb begin
    hit_idx = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_idx = WAY_W'(w);
  end

  always_comb begin
    tag_en   = '0;
    data_en  = '0;
    rd_idx   = q_idx;
    hint_upd = 1'b0;
    upd_way  = pred_way_r;
    fill_now = 1'b0;
    case (state)
      ST_IDLE: begin
        rd_idx = req_idx;
        if (req_valid) begin
          if (hint_match) begin
            tag_en  = way_bit(hint_way);
            data_en = way_bit(hint_way);
          end else begin
            tag_en = '1;
          end
        end
      end
      ST_PRED: begin
        if (any_hit) hint_upd = 1'b1;
        else tag_en = ~way_bit(pred_way_r);
      end
      ST_PHASE, ST_REST: if (any_hit) data_en = way_bit(hit_idx);
      ST_DATA: begin
        hint_upd = 1'b1;
        upd_way  = hit_way_r;
      end
      ST_FILL: if (refill_rsp_valid) begin
        fill_now = 1'b1;
        hint_upd = 1'b1;
        upd_way  = victim;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state            <= ST_IDLE;
      rsp_valid        <= 1'b0;
      rsp_data         <= '0;
      refill_req_valid <= 1'b0;
      refill_req_addr  <= '0;
      tag_rd_count     <= '0;
      data_rd_count    <= '0;
      q_tag            <= '0;
      q_idx            <= '0;
      q_wsel           <= '0;
      pred_way_r       <= '0;
      hit_way_r        <= '0;
      rd_mask          <= '0;
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else begin
      rsp_valid     <= 1'b0;
      tag_rd_count  <= tag_rd_count + CW'($countones(tag_en));
      data_rd_count <= data_rd_count + CW'($countones(data_en));
      case (state)
        ST_IDLE: if (req_valid) begin
          q_tag  <= req_tag;
          q_idx  <= req_idx;
          q_wsel <= req_wsel;
          if (hint_match) begin
            pred_way_r <= hint_way;
            rd_mask    <= way_bit(hint_way);
            state      <= ST_PRED;
          end else begin
            rd_mask <= '1;
            state   <= ST_PHASE;
          end
        end
        ST_PRED: begin
          if (any_hit) begin
            rsp_valid <= 1'b1;
            rsp_data  <= data_q[pred_way_r][q_wsel*DW +: DW];
            state     <= ST_IDLE;
          end else begin
            rd_mask <= ~way_bit(pred_way_r);
            state   <= ST_REST;
          end
        end
        ST_PHASE, ST_REST: begin
          if (any_hit) begin
            hit_way_r <= hit_idx;
            state     <= ST_DATA;
          end else begin
            refill_req_valid <= 1'b1;
            refill_req_addr  <= {q_tag, q_idx, {OFF_W{1'b0}}};
            state            <= ST_FILL;
          end
        end
        ST_DATA: begin
          rsp_valid <= 1'b1;
          rsp_data  <= data_q[hit_way_r][q_wsel*DW +: DW];
          state     <= ST_IDLE;
        end
        ST_FILL: if (refill_rsp_valid) begin
          vld[q_idx][victim] <= 1'b1;
          refill_req_valid   <= 1'b0;
          rsp_valid          <= 1'b1;
          rsp_data           <= refill_rsp_data[q_wsel*DW +: DW];
          state              <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pab_cache_chk.sv
module pab_cache_chk #(
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 16,
  parameter int AW         = 32,
  parameter int CW         = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          refill_req_valid,
  input logic [AW-1:0] refill_req_addr,
  input logic          refill_rsp_valid,
  input logic [CW-1:0] tag_rd_count,
  input logic [CW-1:0] data_rd_count
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_idle_on_rsp_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);

  assert_refill_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (refill_req_valid && !refill_rsp_valid) |=> (refill_req_valid && $stable(refill_req_addr)));

  assert_refill_aligned_R5: assert property (@(posedge clk) disable iff (rst)
    refill_req_valid |-> (refill_req_addr[OFF_W-1:0] == '0));

  assert_tag_step_R10: assert property (@(posedge clk) disable iff (rst)
    (CW'(tag_rd_count - $past(tag_rd_count)) <= CW'(WAYS)));

  assert_data_step_R10: assert property (@(posedge clk) disable iff (rst)
    (CW'(data_rd_count - $past(data_rd_count)) <= CW'(1)));
endmodule

bind pab_cache pab_cache_chk #(.WAYS(WAYS), .LINE_BYTES(LINE_BYTES), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .refill_req_valid(refill_req_valid),
  .refill_req_addr(refill_req_addr), .refill_rsp_valid(refill_rsp_valid),
  .tag_rd_count(tag_rd_count), .data_rd_count(data_rd_count)
);

// File: tb/tb_pab_cache.sv
module tb_pab_cache;
  localparam int WAYS = 2, SETS = 4, LB = 8, AW = 16, DW = 32, CW = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready, rsp_valid, refill_req_valid;
  logic [AW-1:0] req_addr = '0, refill_req_addr;
  logic [DW-1:0] rsp_data;
  logic refill_rsp_valid = 1'b0;
  logic [LB*8-1:0] refill_rsp_data = '0;
  logic [CW-1:0] tag_rd_count, data_rd_count;

  int checks = 0, errors = 0;
  bit done = 0, refill_seen = 0;
  logic [AW-1:0] last_ra;
  int m_tag [SETS][WAYS];
  bit m_vld [SETS][WAYS];
  int m_rr [SETS];
  bit b_valid = 0;
  int b_tag = 0, b_way = 0;
  int cls_cnt [5];

  always #10 clk = ~clk;

  pab_cache #(.WAYS(WAYS), .SETS(SETS), .LINE_BYTES(LB), .AW(AW), .DW(DW), .CW(CW)) dut (.*);

  function automatic logic [31:0] mw(input int a);
    return 32'((a >> 2) * 32'h01000193) ^ 32'hC0DE0000;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (refill_req_valid && !refill_rsp_valid) begin
      refill_seen = 1;
      last_ra = refill_req_addr;
      repeat (2) @(negedge clk);
      refill_rsp_data  = {mw(int'(last_ra) + 4), mw(int'(last_ra))};
      refill_rsp_valid = 1'b1;
      @(negedge clk);
      refill_rsp_valid = 1'b0;
    end
  end

  // classes: 0 predicted hit, 1 predicted-then-other-way hit, 2 phased hit, 3 predicted miss, 4 phased miss
  task automatic access(input int t, input int ix, input int ws);
    int a = (t << 5) | (ix << 3) | (ws << 2);
    int cls, way = -1, lat = 0;
    int tc0, dc0;
    int exp_t[5] = '{1, WAYS, WAYS, WAYS, WAYS};
    int exp_d[5] = '{1, 2, 1, 1, 0};
    int exp_l[5] = '{1, 3, 2, 0, 0};
    string rq[5] = '{"R2", "R4", "R3", "R5", "R5"};
    for (int w = 0; w < WAYS; w++) if (m_vld[ix][w] && m_tag[ix][w] == t) way = w;
    if (b_valid && b_tag == t) cls = (way == b_way) ? 0 : (way >= 0 ? 1 : 3);
    else cls = (way >= 0) ? 2 : 4;
    cls_cnt[cls]++;
    refill_seen = 0;
    @(negedge clk);
    tc0 = int'(tag_rd_count); dc0 = int'(data_rd_count);
    req_valid = 1'b1; req_addr = AW'(a);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9 busy after accept", int'(req_ready), 0);
    while (!rsp_valid) begin @(negedge clk); lat++; end
    chk(rsp_data == mw(a), "R8 read word", int'(rsp_data), int'(mw(a)));
    chk(int'(tag_rd_count) - tc0 == exp_t[cls], {rq[cls], " R10 tag reads"}, int'(tag_rd_count) - tc0, exp_t[cls]);
    chk(int'(data_rd_count) - dc0 == exp_d[cls], {rq[cls], " R10 data reads"}, int'(data_rd_count) - dc0, exp_d[cls]);
    chk(refill_seen == (cls >= 3), "R6 refill occurrence", int'(refill_seen), int'(cls >= 3));
    if (cls < 3) chk(lat == exp_l[cls], {rq[cls], " latency"}, lat, exp_l[cls]);
    else chk(last_ra == AW'(a & ~(LB - 1)), "R5 refill address", int'(last_ra), a & ~(LB - 1));
    if (cls >= 3) begin
      way = m_rr[ix];
      m_tag[ix][way] = t; m_vld[ix][way] = 1;
      m_rr[ix] = (m_rr[ix] + 1) % WAYS;
    end
    b_valid = 1; b_tag = t; b_way = way;   // R7 hint follows every hit and fill
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin m_vld[s][w] = 0; m_tag[s][w] = 0; end
    end
    for (int k = 0; k < 5; k++) cls_cnt[k] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 no response", int'(rsp_valid), 0);
    chk(refill_req_valid == 1'b0, "R1 no refill", int'(refill_req_valid), 0);
    chk(tag_rd_count == '0 && data_rd_count == '0, "R1 counters", int'(tag_rd_count), 0);
    for (int t = 0; t < 3; t++)
      for (int i = 0; i < SETS; i++)
        for (int w = 0; w < 2; w++) access(t, i, w);
    for (int i = 0; i < SETS; i++)
      for (int t = 0; t < 3; t++) begin access(t, i, 1); access(t, i, 0); end
    for (int r = 0; r < 4; r++) begin
      access(20 + r, 0, 0);
      access(20 + r, 1, 0);
      if (r == 1) access(41, 1, 1);
      access(20 + r, 0, 1);
      access(20 + r, 1, 1);
    end
    chk(cls_cnt[0] > 0, "R2 predicted hits seen", cls_cnt[0], 1);
    chk(cls_cnt[1] > 0, "R4 other-way hits seen", cls_cnt[1], 1);
    chk(cls_cnt[2] > 0, "R3 phased hits seen", cls_cnt[2], 1);
    chk(cls_cnt[3] + cls_cnt[4] > 0, "R5 misses seen", cls_cnt[4], 1);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule